// File: doc/BRIEF.md
# Serial transceiver mode selector

This block is a small register bank that sits between a simple register bus and a UART core. It holds three read-only identification bytes (version, revision and a capability bitmap) and a writable control byte that chooses which external line transceiver is driven. The four choices are off, RS485, RS422 and RS232. The chosen mode is decoded into separate enable outputs, one for each transceiver.

A write that asks for a mode whose capability bit is clear is dropped. The off mode is always accepted, so software can switch every transceiver off before it selects a new one. This gives break-before-make switching. Bus accesses at byte offsets from the UART base upward are not handled locally. They are passed through to a downstream port, with the byte offset turned into a register index.

The mode is held in a four-state machine. The states are `MODE_OFF` (code 0), `MODE_RS485` (code 1), `MODE_RS422` (code 2) and `MODE_RS232` (code 3). There is one transition, "accept", from any state to any state. It is taken on a control write whose requested code is 0 or has its capability bit set. Every other cycle is the transition "hold", which keeps the current state.

Top module: `xcvr_mode_sel`

## Requirements
- R1: After reset, the mode output is 0, all transceiver enables are low, `rsp_valid` is low and `win_sel` is low.
- R2: Reads return the `VERSION` parameter at offset 0x0, `REVISION` at 0x1 and the capability bitmap (bits 3:0, upper bits zero) at 0x2. Writes to these three offsets change neither the values read back nor the mode.
- R3: A write to offset 0x4 whose bits 1:0 hold a supported code takes effect on the clock edge that accepts the write. The mode output shows the new code from that edge onward. The codes are 0 = off, 1 = RS485, 2 = RS422 and 3 = RS232.
- R4: A control write of code 1, 2 or 3 whose capability bit (bit N for code N) is clear is ignored. The mode keeps its previous value.
- R5: A control write of code 0 is always accepted, from any mode, whatever the capability bits hold.
- R6: `xcvr_en` bit 0 is the RS485 enable, bit 1 the RS422 enable and bit 2 the RS232 enable. Exactly the bit of the current mode is high for codes 1 to 3. No bit is high for code 0.
- R7: A read of offset 0x4 returns the current mode in bits 1:0 and zero in bits 7:2. Bits 7:2 of a control write are ignored.
- R8: A request at a byte offset of 0x0C or above asserts `win_sel` in the same cycle. In that cycle `win_write` and `win_wdata` follow the request, and `win_index` equals (offset − 0x0C) >> 2. Such a request never changes the mode.
- R9: Every read request is answered one cycle later with `rsp_valid` high. For window offsets, `rsp_rdata` holds the value `win_rdata` had in the request cycle.
- R10: Reads of local offsets that have no register (0x3 and 0x5 to 0x0B) return zero. Writes to those offsets change nothing, and `win_sel` stays low for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 8 | Read data |
| mode_o | output | 2 | Current mode code |
| xcvr_en | output | 3 | Transceiver enables: bit 0 RS485, bit 1 RS422, bit 2 RS232 |
| win_sel | output | 1 | Request targets the UART window |
| win_write | output | 1 | Window access is a write |
| win_index | output | IDX_W | UART register index |
| win_wdata | output | 8 | Window write data |
| win_rdata | input | 8 | Window read data, sampled in the request cycle |

## Verification
The hardest case to bring about from the ports is a rejected change between two modes that are both live. It needs the machine to sit in a non-off state first, then receive a request for a code that the capability map leaves out. The bench drives every pair of starting and requested modes. It reaches each starting mode through an accepted write and then issues the requested code. It derives the expected mode from the capability parameter, so rejected writes from every live state are covered. The default capability map leaves out RS422, so that state is only ever requested and never reached.

// File: rtl/xms_pkg.sv
package xms_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RS485 = 2'd1,
        MODE_RS422 = 2'd2,
        MODE_RS232 = 2'd3
    } mode_e;

    localparam int NUM_MODES = 4;
    localparam int NUM_XCVR  = NUM_MODES - 1;
    localparam int DATA_W    = 8;

    // local register byte offsets (software-visible layout)
    localparam int OFS_VER = 'h0;
    localparam int OFS_REV = 'h1;
    localparam int OFS_CAP = 'h2;
    localparam int OFS_CTL = 'h4;
endpackage

// File: rtl/xms_addr_dec.sv
module xms_addr_dec #(
    parameter int ADDR_W    = 8,
    parameter int UART_BASE = 12,
    parameter int REG_SHIFT = 2,
    parameter int IDX_W     = ADDR_W - REG_SHIFT
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_ver,
    output logic              sel_rev,
    output logic              sel_cap,
    output logic              sel_ctl,
    output logic              sel_win,
    output logic [IDX_W-1:0]  index
);
    import xms_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(UART_BASE);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        sel_win = (addr >= BASE_A);
        sel_ver = !sel_win && (addr == ADDR_W'(OFS_VER));
        sel_rev = !sel_win && (addr == ADDR_W'(OFS_REV));
        sel_cap = !sel_win && (addr == ADDR_W'(OFS_CAP));
        sel_ctl = !sel_win && (addr == ADDR_W'(OFS_CTL));
        rel     = addr - BASE_A;
        index   = sel_win ? IDX_W'(rel >> REG_SHIFT) : '0;
    end
endmodule

// File: rtl/xms_mode_fsm.sv
module xms_mode_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_ctl,
    input  logic [1:0]               wr_code,
    input  logic [xms_pkg::NUM_MODES-1:0] cap,
    output xms_pkg::mode_e           state
);
    import xms_pkg::*;

    mode_e req_mode;
    mode_e state_nx;
    logic  allowed;

    always_comb begin
        req_mode = mode_e'(wr_code);
        allowed  = 1'b0;
        unique case (req_mode)
            MODE_OFF:   allowed = 1'b1;
            MODE_RS485: allowed = cap[1];
            MODE_RS422: allowed = cap[2];
            MODE_RS232: allowed = cap[3];
        endcase
        state_nx = (wr_ctl && allowed) ? req_mode : state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_OFF;
        else        state <= state_nx;
    end

    // R4
    reject_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_code != 2'd0 && !cap[wr_code]) |=> $stable(state));
    // R3
    accept_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && (wr_code == 2'd0 || cap[wr_code])) |=> (state == $past(wr_code)));
    // R5
    off_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wr_code == 2'd0) |=> (state == MODE_OFF));
endmodule

// File: rtl/xms_xcvr_dec.sv
module xms_xcvr_dec (
    input  logic                         clk,
    input  logic                         rst_n,
    input  xms_pkg::mode_e               mode,
    output logic [xms_pkg::NUM_XCVR-1:0] en
);
    import xms_pkg::*;

    always_comb begin
        en = '0;
        unique case (mode)
            MODE_OFF:   en = '0;
            MODE_RS485: en[0] = 1'b1;
            MODE_RS422: en[1] = 1'b1;
            MODE_RS232: en[2] = 1'b1;
        endcase
    end

    // R6
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_OFF) |-> ($countones(en) == 1));
    // R6
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> (en == '0));
endmodule

// File: rtl/xms_rd_mux.sv
module xms_rd_mux #(
    parameter logic [7:0] VERSION  = 8'h01,
    parameter logic [7:0] REVISION = 8'h00,
    parameter logic [3:0] CAPS     = 4'b1011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic       sel_ver,
    input  logic       sel_rev,
    input  logic       sel_cap,
    input  logic       sel_ctl,
    input  logic       sel_win,
    input  logic [1:0] mode_code,
    input  logic [7:0] win_rdata,
    output logic       rsp_valid,
    output logic [7:0] rsp_rdata
);
    logic [7:0] rd_nx;

    always_comb begin
        rd_nx = '0;
        if      (sel_win) rd_nx = win_rdata;
        else if (sel_ver) rd_nx = VERSION;
        else if (sel_rev) rd_nx = REVISION;
        else if (sel_cap) rd_nx = {4'b0, CAPS};
        else if (sel_ctl) rd_nx = {6'b0, mode_code};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) rsp_rdata <= rd_nx;
        end
    end

    // R9
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    // R9
    rsp_only_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid);
    // R7
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel_ctl) |=> (rsp_rdata[7:2] == 6'b0));
endmodule

// File: rtl/xcvr_mode_sel.sv
module xcvr_mode_sel #(
    parameter int         ADDR_W    = 8,
    parameter int         UART_BASE = 12,
    parameter int         REG_SHIFT = 2,
    parameter logic [7:0] VERSION   = 8'h01,
    parameter logic [7:0] REVISION  = 8'h03,
    parameter logic [3:0] CAPS      = 4'b1011,
    localparam int        IDX_W     = ADDR_W - REG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata,
    output logic [1:0]        mode_o,
    output logic [2:0]        xcvr_en,
    output logic              win_sel,
    output logic              win_write,
    output logic [IDX_W-1:0]  win_index,
    output logic [7:0]        win_wdata,
    input  logic [7:0]        win_rdata
);
    import xms_pkg::*;

    logic  sel_ver, sel_rev, sel_cap, sel_ctl, sel_win;
    logic  wr_ctl, rd_req;
    mode_e state;

    xms_addr_dec #(
        .ADDR_W(ADDR_W), .UART_BASE(UART_BASE),
        .REG_SHIFT(REG_SHIFT), .IDX_W(IDX_W)
    ) u_dec (
        .addr(req_addr), .sel_ver(sel_ver), .sel_rev(sel_rev),
        .sel_cap(sel_cap), .sel_ctl(sel_ctl), .sel_win(sel_win),
        .index(win_index)
    );

    assign wr_ctl = req_valid && req_write && sel_ctl;
    assign rd_req = req_valid && !req_write;

    xms_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl),
        .wr_code(req_wdata[1:0]), .cap(CAPS), .state(state)
    );

    xms_xcvr_dec u_xdec (
        .clk(clk), .rst_n(rst_n), .mode(state), .en(xcvr_en)
    );

    xms_rd_mux #(
        .VERSION(VERSION), .REVISION(REVISION), .CAPS(CAPS)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
        .sel_ver(sel_ver), .sel_rev(sel_rev), .sel_cap(sel_cap),
        .sel_ctl(sel_ctl), .sel_win(sel_win), .mode_code(state),
        .win_rdata(win_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign mode_o    = state;
    assign win_sel   = req_valid && sel_win;
    assign win_write = win_sel && req_write;
    assign win_wdata = req_wdata;

    // R8
    win_no_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |=> $stable(mode_o));
    // R8
    win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |-> !wr_ctl);
endmodule

// File: tb/xcvr_mode_sel_tb.sv
module xcvr_mode_sel_tb;
    localparam int         ADDR_W = 8;
    localparam int         IDX_W  = 6;
    localparam logic [3:0] CAPS   = 4'b1011;
    localparam logic [7:0] VER    = 8'h01;
    localparam logic [7:0] REV    = 8'h03;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_wdata = '0;
    logic              rsp_valid;
    logic [7:0]        rsp_rdata;
    logic [1:0]        mode_o;
    logic [2:0]        xcvr_en;
    logic              win_sel, win_write;
    logic [IDX_W-1:0]  win_index;
    logic [7:0]        win_wdata, win_rdata;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    // downstream model: data depends on the index it is given
    assign win_rdata = {win_index, 2'b10} ^ 8'h5A;

    xcvr_mode_sel #(.VERSION(VER), .REVISION(REV), .CAPS(CAPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mode_o(mode_o), .xcvr_en(xcvr_en),
        .win_sel(win_sel), .win_write(win_write), .win_index(win_index),
        .win_wdata(win_wdata), .win_rdata(win_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] en_of(input logic [1:0] m);
        return (m == 2'd0) ? 3'b000 : 3'(1 << (m - 1));
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 rsp_valid", rsp_valid, 1);
        d = rsp_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        logic [7:0] d;
        logic [1:0] exp_m;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 en", xcvr_en, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 win_sel", win_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode after release", mode_o, 0);

        // R2 identification registers, write attempts ignored
        for (int pass = 0; pass < 2; pass++) begin
            rd(8'h00, d); chk("R2 version", d, VER);
            rd(8'h01, d); chk("R2 revision", d, REV);
            rd(8'h02, d); chk("R2 capability", d, {4'b0, CAPS});
            wr(8'h00, 8'hFF); wr(8'h01, 8'hFF); wr(8'h02, 8'hFF);
            chk("R2 mode untouched", mode_o, 0);
        end

        // R3 R4 R5 R6 R7: every start mode to every requested code
        for (int from = 0; from < 4; from++) begin
            if (from != 0 && !CAPS[from]) continue;
            for (int to = 0; to < 4; to++) begin
                wr(8'h04, 8'h00);
                wr(8'h04, 8'(from));
                chk("R3 start mode", mode_o, from);
                exp_m = (to == 0 || CAPS[to]) ? 2'(to) : 2'(from);
                // upper write bits set to show they are ignored (R7)
                wr(8'h04, 8'hA4 | 8'(to));
                if (to == 0)       chk("R5 off accepted", mode_o, exp_m);
                else if (CAPS[to]) chk("R3 accepted", mode_o, exp_m);
                else               chk("R4 rejected", mode_o, exp_m);
                chk("R6 enables", xcvr_en, en_of(exp_m));
                rd(8'h04, d);
                chk("R7 readback", d, {6'b0, exp_m});
            end
        end

        // R10 unmapped local offsets; R8 win_sel low locally
        wr(8'h04, 8'h03);
        for (int a = 0; a < 12; a++) begin
            if (a == 0 || a == 1 || a == 2 || a == 4) continue;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(a);
            #1 chk("R10 win_sel low", win_sel, 0);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R10 read zero", rsp_rdata, 0);
            wr(8'(a), 8'h01);
            chk("R10 write no effect", mode_o, 3);
        end

        // R8 R9 window sweep
        for (int a = 12; a < 256; a++) begin
            logic [IDX_W-1:0] ix;
            ix = IDX_W'((a - 12) >> 2);
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 8'(a); req_wdata = 8'(a) ^ 8'h3C;
            #1;
            chk("R8 win_sel wr", win_sel, 1);
            chk("R8 win_write", win_write, 1);
            chk("R8 win_index", win_index, ix);
            chk("R8 win_wdata", win_wdata, 8'(a) ^ 8'h3C);
            @(negedge clk);
            req_write = 1'b0; req_wdata = 8'h01;
            #1 chk("R8 win_write low on read", win_write, 0);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R9 window read data", rsp_rdata, {ix, 2'b10} ^ 8'h5A);
            chk("R8 mode untouched", mode_o, 3);
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule